// File: doc/BRIEF.md
# MII Receive-Side Delivery and Line Status Unit

This block sits on the PHY side of a 4-bit media independent interface and delivers received nibbles to the MAC. A decoder upstream supplies one nibble per receive-clock period, together with flags that mark a preamble nibble, the start-of-frame delimiter nibble and the final data nibble of a frame, plus a level that is high while the receiver sees a non-idle line. From these the block builds the receive clock, the data-valid strobe and the data nibble. Data-valid is placed by a different rule at each line speed. The block also folds transmit and receive activity into carrier-sense and collision levels.

The receive clock is divided from the block clock, with a separate half-period for the fast mode and the slow mode. The falling edge of the receive clock is the nibble tick: inputs are captured on one tick and presented on the next, so each output nibble is stable across a MAC rising edge. In the fast mode an enable can hold the receive clock low while the line is idle. Any new activity restarts it a full period before data-valid rises. An isolate input drops the shared output enable of the MAC-facing pins. A repeater input keeps the block's own transmit activity out of carrier sense. A duplex input suppresses collision. In the slow mode, after each transmission, the collision pin carries a short heartbeat pulse.

Top module: `rxmii_front`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `rx_dv_o`, `crs_o` and `col_o` are low and `rxd_o` is zero, whatever the other inputs do.
- R2: The internal receive clock toggles every HALF_FAST block-clock cycles when `spd100_i` is 1 and every HALF_SLOW cycles when it is 0. Counting the first rising block-clock edge after reset as edge 1, it rises at edge HALF and falls at edge 2*HALF, and so on. Each falling edge is a nibble tick. With no gating, `rx_clk_o` equals this clock.
- R3: The nibble inputs (`rx_act_i`, `rx_nib_i`, `rx_pre_i`, `rx_sfd_i`, `rx_last_i`) are captured at a tick. The matching `rx_dv_o`/`rxd_o` appear after the following tick and hold for one receive-clock period.
- R4: In fast mode, `rx_dv_o` is 1 for every captured active nibble from the first one of a frame (the first preamble nibble) up to and including the nibble flagged last, and `rxd_o` carries that nibble.
- R5: In slow mode, active nibbles before the one flagged SFD are delivered with `rx_dv_o`=0 and `rxd_o`=0. The SFD-flagged nibble is delivered with `rx_dv_o`=1, and so is every nibble after it up to and including the one flagged last. An active nibble before the SFD that carries neither the preamble nor the SFD flag discards the rest of that frame.
- R6: After the nibble flagged last, or after a discard, further active nibbles are delivered with `rx_dv_o`=0 until a tick captures `rx_act_i`=0. Whenever `rx_dv_o` is 0, `rxd_o` is 0.
- R7: `crs_o` equals `rx_act_i | (tx_act_i & ~rep_i)` sampled at the previous block-clock edge.
- R8: `col_o` equals `tx_act_i & rx_act_i & ~full_dpx_i` sampled at the previous edge. It is always 0 after an edge that sampled `full_dpx_i`=1, and outside the heartbeat of R9.
- R9: In slow mode and half duplex, when `tx_act_i` falls, `col_o` is 1 after edges SQE_GAP+2 through SQE_GAP+SQE_LEN+1, counting the first edge that samples `tx_act_i` low as edge 1. There is no such pulse in fast mode.
- R10: With `gate_en_i`=1 in fast mode, `rx_clk_o` is held low from the first tick at which both the current input and the captured nibble are inactive. A tick that captures an active nibble releases it, so `rx_clk_o` rises half a period later and `rx_dv_o` rises at the next tick. In slow mode or with `gate_en_i`=0 the clock is never held.
- R11: `mii_oe_o` is 0 while `iso_i` is 1 and 1 while it is 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spd100_i | input | 1 | 1 = fast mode, 0 = slow mode |
| rep_i | input | 1 | Repeater mode: transmit activity left out of carrier sense |
| full_dpx_i | input | 1 | Full duplex: collision suppressed |
| iso_i | input | 1 | Isolate: MAC-facing outputs released |
| gate_en_i | input | 1 | Allow idle receive-clock hold in fast mode |
| tx_act_i | input | 1 | Transmitter non-idle |
| rx_act_i | input | 1 | Receiver non-idle; qualifies the nibble inputs |
| rx_nib_i | input | NIB_W | Decoded receive nibble |
| rx_pre_i | input | 1 | Nibble is preamble |
| rx_sfd_i | input | 1 | Nibble is the start-of-frame delimiter |
| rx_last_i | input | 1 | Nibble is the final data nibble |
| rx_clk_o | output | 1 | Receive clock toward the MAC |
| rx_dv_o | output | 1 | Receive data valid |
| rxd_o | output | NIB_W | Receive data nibble |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision / heartbeat |
| mii_oe_o | output | 1 | Output enable for all MAC-facing outputs |

## Verification
A wrong frame state, such as a missed SFD in slow mode or a state stuck after the last nibble, shows on `rx_dv_o` and `rxd_o` two ticks after the nibble that caused it, and it repeats on every later nibble of that frame. A wrong capture stage or tick phase shifts every delivered nibble by a whole receive period, and each sampled tick exposes it. A wrong gating flag shows as `rx_clk_o` running during idle or missing its rising edge before `rx_dv_o` rises, within one receive period. Carrier-sense and collision errors, including a heartbeat counter that starts late or runs long, show one block-clock cycle after the input edge that should have produced them.

// File: rtl/rxmii_pkg.sv
package rxmii_pkg;

   // frame tracking states of the delivery stage
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_HUNT = 2'd1,
      FS_PASS = 2'd2,
      FS_TAIL = 2'd3
   } frm_st_t;

   // per-nibble qualifiers captured with the nibble
   typedef struct packed {
      logic act;
      logic pre;
      logic sfd;
      logic last;
   } beat_flags_t;

endpackage

// File: rtl/rxmii_clkgen.sv
module rxmii_clkgen #(
   parameter int HALF_FAST = 2,
   parameter int HALF_SLOW = 20,
   parameter bit GATE_OK   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic spd100_i,
   input  logic gate_en_i,
   input  logic busy_i,
   output logic rx_clk_o,
   output logic fall_tick_o,
   output logic gated_o
);
   localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
   localparam int CW   = $clog2(HMAX) + 1;

   if (HALF_FAST < 1) begin : g_bad_fast
      $error("rxmii_clkgen: HALF_FAST must be at least 1");
   end
   if (HALF_SLOW < 1) begin : g_bad_slow
      $error("rxmii_clkgen: HALF_SLOW must be at least 1");
   end

   logic [CW-1:0] ph_q;
   logic [CW-1:0] lim;
   logic          rxc_q;
   logic          turn;

   assign lim  = spd100_i ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
   assign turn = (ph_q >= lim);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= '0;
         rxc_q <= 1'b0;
      end else if (turn) begin
         ph_q  <= '0;
         rxc_q <= ~rxc_q;
      end else begin
         ph_q  <= ph_q + CW'(1);
      end
   end

   assign fall_tick_o = turn & rxc_q;

   if (GATE_OK) begin : g_gate
      logic hold_q;
      // the hold flag moves only when the divided clock falls, so the
      // visible clock never shows a shortened pulse
      always_ff @(posedge clk) begin
         if (rst) begin
            hold_q <= 1'b0;
         end else if (fall_tick_o) begin
            hold_q <= gate_en_i & spd100_i & ~busy_i;
         end
      end
      assign gated_o = hold_q;

      // R10
      gate_speed_chk: assert property (@(posedge clk) disable iff (rst)
         (hold_q && !$past(hold_q)) |-> $past(spd100_i && gate_en_i && !busy_i));
   end else begin : g_free
      logic unused_gate;
      assign unused_gate = gate_en_i | busy_i;
      assign gated_o     = 1'b0;
   end

   assign rx_clk_o = rxc_q & ~gated_o;

   // R2
   clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_clk_o) |-> $past(turn) || $past(fall_tick_o) || gated_o);

endmodule

// File: rtl/rxmii_framer.sv
module rxmii_framer
   import rxmii_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             spd100_i,
   input  beat_flags_t      flags_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic             rx_dv_o,
   output logic [NIB_W-1:0] rxd_o,
   output logic             busy_o
);
   if (NIB_W < 1) begin : g_bad_w
      $error("rxmii_framer: NIB_W must be at least 1");
   end

   beat_flags_t      s1_f;
   logic [NIB_W-1:0] s1_nib;
   frm_st_t          st_q, st_d;
   logic             dv_q, dv_d;
   logic [NIB_W-1:0] rxd_q, rxd_d;

   // capture stage: one receive period of look-ahead
   always_ff @(posedge clk) begin
      if (rst) begin
         s1_f   <= '0;
         s1_nib <= '0;
      end else if (tick_i) begin
         s1_f   <= flags_i;
         s1_nib <= nib_i;
      end
   end

   always_comb begin
      st_d  = st_q;
      dv_d  = 1'b0;
      rxd_d = '0;
      if (!s1_f.act) begin
         st_d = FS_IDLE;
      end else begin
         unique case (st_q)
            FS_IDLE, FS_HUNT: begin
               if (spd100_i || s1_f.sfd) begin
                  dv_d  = 1'b1;
                  rxd_d = s1_nib;
                  st_d  = s1_f.last ? FS_TAIL : FS_PASS;
               end else if (s1_f.pre) begin
                  st_d = FS_HUNT;
               end else begin
                  st_d = FS_TAIL;
               end
            end
            FS_PASS: begin
               dv_d  = 1'b1;
               rxd_d = s1_nib;
               st_d  = s1_f.last ? FS_TAIL : FS_PASS;
            end
            default: begin
               st_d = FS_TAIL;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= FS_IDLE;
         dv_q  <= 1'b0;
         rxd_q <= '0;
      end else if (tick_i) begin
         st_q  <= st_d;
         dv_q  <= dv_d;
         rxd_q <= rxd_d;
      end
   end

   assign rx_dv_o = dv_q;
   assign rxd_o   = rxd_q;
   assign busy_o  = flags_i.act | s1_f.act;

   // R6
   idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_dv_o |-> (rxd_o == '0));

   // R5
   slow_sfd_rise_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(rx_dv_o) && !$past(spd100_i)) |-> $past(s1_f.sfd));

   // R3
   tick_only_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(tick_i) |-> ($stable(rx_dv_o) && $stable(rxd_o)));

endmodule

// File: rtl/rxmii_status.sv
module rxmii_status #(
   parameter bit SQE_EN  = 1'b1,
   parameter int SQE_GAP = 8,
   parameter int SQE_LEN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic spd100_i,
   input  logic rep_i,
   input  logic full_dpx_i,
   input  logic tx_act_i,
   input  logic rx_act_i,
   output logic crs_o,
   output logic col_o
);
   localparam int SQE_TOT = SQE_GAP + SQE_LEN;
   localparam int SW      = $clog2(SQE_TOT + 1);

   if (SQE_LEN < 1) begin : g_bad_len
      $error("rxmii_status: SQE_LEN must be at least 1");
   end
   if (SQE_GAP < 0) begin : g_bad_gap
      $error("rxmii_status: SQE_GAP must not be negative");
   end

   logic sqe_on;

   if (SQE_EN) begin : g_sqe
      logic          tx_d_q;
      logic [SW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            tx_d_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            tx_d_q <= tx_act_i;
            if (tx_d_q && !tx_act_i) begin
               cnt_q <= SW'(SQE_TOT);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - SW'(1);
            end
         end
      end
      assign sqe_on = (cnt_q != '0) && (cnt_q <= SW'(SQE_LEN));
   end else begin : g_nosqe
      assign sqe_on = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         crs_o <= 1'b0;
         col_o <= 1'b0;
      end else begin
         crs_o <= rx_act_i | (tx_act_i & ~rep_i);
         col_o <= ~full_dpx_i & ((tx_act_i & rx_act_i) | (sqe_on & ~spd100_i));
      end
   end

   // R8
   full_no_col_chk: assert property (@(posedge clk) disable iff (rst)
      $past(full_dpx_i) |-> !col_o);

   // R7
   rep_crs_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rep_i) && !$past(rx_act_i)) |-> !crs_o);

   // R9
   fast_no_hb_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(spd100_i) && !$past(rx_act_i)) |-> !col_o);

endmodule

// File: rtl/rxmii_front.sv
module rxmii_front
   import rxmii_pkg::*;
#(
   parameter int NIB_W     = 4,
   parameter int HALF_FAST = 2,
   parameter int HALF_SLOW = 20,
   parameter bit GATE_OK   = 1'b1,
   parameter bit SQE_EN    = 1'b1,
   parameter int SQE_GAP   = 8,
   parameter int SQE_LEN   = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             spd100_i,
   input  logic             rep_i,
   input  logic             full_dpx_i,
   input  logic             iso_i,
   input  logic             gate_en_i,
   input  logic             tx_act_i,
   input  logic             rx_act_i,
   input  logic [NIB_W-1:0] rx_nib_i,
   input  logic             rx_pre_i,
   input  logic             rx_sfd_i,
   input  logic             rx_last_i,
   output logic             rx_clk_o,
   output logic             rx_dv_o,
   output logic [NIB_W-1:0] rxd_o,
   output logic             crs_o,
   output logic             col_o,
   output logic             mii_oe_o
);
   if (HALF_SLOW < HALF_FAST) begin : g_bad_ratio
      $error("rxmii_front: HALF_SLOW must not be below HALF_FAST");
   end

   logic        tick;
   logic        gated;
   logic        busy;
   beat_flags_t flags;

   assign flags = '{act: rx_act_i, pre: rx_pre_i, sfd: rx_sfd_i, last: rx_last_i};

   rxmii_clkgen #(
      .HALF_FAST (HALF_FAST),
      .HALF_SLOW (HALF_SLOW),
      .GATE_OK   (GATE_OK)
   ) clkgen_i (
      .clk         (clk),
      .rst         (rst),
      .spd100_i    (spd100_i),
      .gate_en_i   (gate_en_i),
      .busy_i      (busy),
      .rx_clk_o    (rx_clk_o),
      .fall_tick_o (tick),
      .gated_o     (gated)
   );

   rxmii_framer #(
      .NIB_W (NIB_W)
   ) framer_i (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick),
      .spd100_i (spd100_i),
      .flags_i  (flags),
      .nib_i    (rx_nib_i),
      .rx_dv_o  (rx_dv_o),
      .rxd_o    (rxd_o),
      .busy_o   (busy)
   );

   rxmii_status #(
      .SQE_EN  (SQE_EN),
      .SQE_GAP (SQE_GAP),
      .SQE_LEN (SQE_LEN)
   ) status_i (
      .clk        (clk),
      .rst        (rst),
      .spd100_i   (spd100_i),
      .rep_i      (rep_i),
      .full_dpx_i (full_dpx_i),
      .tx_act_i   (tx_act_i),
      .rx_act_i   (rx_act_i),
      .crs_o      (crs_o),
      .col_o      (col_o)
   );

   assign mii_oe_o = ~iso_i;

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rx_dv_o && !crs_o && !col_o && rxd_o == '0));

   // R10
   dv_clock_live_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_dv_o) |-> (!gated && !$past(gated)));

endmodule

// File: tb/rxmii_front_tb_top.sv
module rxmii_front_tb_top;
   localparam int HF   = 2;
   localparam int HS   = 20;
   localparam int GAP  = 8;
   localparam int LEN  = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       spd = 1'b1, rep = 1'b0, full = 1'b0, iso = 1'b0, gen = 1'b0;
   logic       tx = 1'b0, ract = 1'b0, pre = 1'b0, sfd = 1'b0, last = 1'b0;
   logic [3:0] nib = 4'h0;
   logic       rx_clk_o, rx_dv_o, crs_o, col_o, mii_oe_o;
   logic [3:0] rxd_o;

   int n_chk = 0;
   int n_err = 0;
   int cnt   = 0;
   int sl    = 0;
   int m_st  = 0;
   int exp_dv  [4];
   int exp_rxd [4];

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (rst) cnt <= 0;
      else     cnt <= cnt + 1;
   end

   rxmii_front #(
      .NIB_W(4), .HALF_FAST(HF), .HALF_SLOW(HS), .GATE_OK(1'b1),
      .SQE_EN(1'b1), .SQE_GAP(GAP), .SQE_LEN(LEN)
   ) dut_i (
      .clk(clk), .rst(rst), .spd100_i(spd), .rep_i(rep), .full_dpx_i(full),
      .iso_i(iso), .gate_en_i(gen), .tx_act_i(tx), .rx_act_i(ract),
      .rx_nib_i(nib), .rx_pre_i(pre), .rx_sfd_i(sfd), .rx_last_i(last),
      .rx_clk_o(rx_clk_o), .rx_dv_o(rx_dv_o), .rxd_o(rxd_o), .crs_o(crs_o),
      .col_o(col_o), .mii_oe_o(mii_oe_o)
   );

   function automatic int per();
      return spd ? 2 * HF : 2 * HS;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cnt);
      end
   endtask

   // one block-clock cycle; carrier sense and collision follow the inputs
   task automatic step();
      @(negedge clk);
      check("R7 carrier sense", crs_o, ract | (!rep & tx));
      if (spd || full) check("R8 collision", col_o, !full & tx & ract);
   endtask

   task automatic to_tick();
      do step(); while (cnt % per() != 0);
   endtask

   task automatic do_reset(input logic s, input logic g);
      @(negedge clk);
      rst = 1'b1; spd = s; gen = g;
      ract = 1'b1; tx = 1'b1; rep = 1'b0; full = 1'b0; nib = 4'hA; sfd = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 rx_dv in reset", rx_dv_o, 0);
      check("R1 rxd in reset", rxd_o, 0);
      check("R1 crs in reset", crs_o, 0);
      check("R1 col in reset", col_o, 0);
      ract = 1'b0; tx = 1'b0; nib = 4'h0; sfd = 1'b0; pre = 1'b0; last = 1'b0;
      rst = 1'b0;
      sl = 0; m_st = 0;
   endtask

   // expected delivery of one captured nibble, from R4, R5 and R6
   task automatic model(input logic a, input logic [3:0] n, input logic p,
                        input logic s, input logic l, output int edv, output int erxd);
      edv = 0; erxd = 0;
      if (!a) m_st = 0;
      else if (m_st <= 1) begin
         if (spd || s) begin edv = 1; erxd = int'(n); m_st = l ? 3 : 2; end
         else m_st = p ? 1 : 3;
      end else if (m_st == 2) begin
         edv = 1; erxd = int'(n); m_st = l ? 3 : 2;
      end
   endtask

   task automatic drive_slot(input logic a, input logic [3:0] n, input logic p,
                             input logic s, input logic l);
      int edv, erxd;
      to_tick();
      if (sl >= 2) begin
         check(spd ? "R4 fast rx_dv" : "R5 slow rx_dv", rx_dv_o, exp_dv[(sl - 2) % 4]);
         check(exp_dv[(sl - 2) % 4] != 0 ? "R3 rxd" : "R6 rxd idle", rxd_o,
               exp_rxd[(sl - 2) % 4]);
      end
      ract = a; nib = n; pre = p; sfd = s; last = l;
      tx = 1'($urandom_range(0, 1)); rep = 1'($urandom_range(0, 1));
      full = 1'($urandom_range(0, 1));
      model(a, n, p, s, l, edv, erxd);
      exp_dv[sl % 4] = edv; exp_rxd[sl % 4] = erxd;
      sl++;
   endtask

   task automatic send_frame(input int npre, input int ndat, input int ntail, input bit noise);
      for (int i = 0; i < npre; i++) drive_slot(1'b1, 4'h5, 1'b1, 1'b0, 1'b0);
      if (noise) drive_slot(1'b1, 4'h3, 1'b0, 1'b0, 1'b0);
      drive_slot(1'b1, 4'hD, 1'b0, 1'b1, (ndat == 0));
      for (int i = 0; i < ndat; i++)
         drive_slot(1'b1, 4'($urandom_range(0, 15)), 1'b0, 1'b0, (i == ndat - 1));
      for (int i = 0; i < ntail; i++)
         drive_slot(1'b1, 4'($urandom_range(1, 15)), 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) drive_slot(1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      int t0;
      void'($urandom(32'd20240611));

      // fast mode, free clock
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < 12; i++) begin
         step();
         check("R2 fast clock", rx_clk_o, (cnt % (2 * HF)) >= HF);
      end

      // isolate
      iso = 1'b1; #1;
      check("R11 isolate", mii_oe_o, 0);
      step();
      iso = 1'b0; #1;
      check("R11 release", mii_oe_o, 1);

      // fast-mode frames, random lengths
      for (int f = 0; f < 14; f++)
         send_frame($urandom_range(1, 8), $urandom_range(0, 12), $urandom_range(0, 2), 1'b0);

      // directed status cases
      full = 1'b0; rep = 1'b1; ract = 1'b1; tx = 1'b1; step(); step();
      ract = 1'b0; step(); step();
      rep = 1'b0; step(); step();
      full = 1'b1; ract = 1'b1; step(); step();
      full = 1'b0; ract = 1'b0; tx = 1'b1; step(); tx = 1'b0;
      for (int i = 0; i < GAP + LEN + 4; i++) begin
         step();
         check("R9 no heartbeat fast", col_o, 0);
      end

      // slow mode
      do_reset(1'b0, 1'b0);
      for (int i = 0; i < 90; i++) begin
         step();
         check("R2 slow clock", rx_clk_o, (cnt % (2 * HS)) >= HS);
      end
      send_frame(4, 6, 2, 1'b0);
      send_frame(2, 0, 0, 1'b0);
      send_frame(3, 5, 1, 1'b1);
      for (int f = 0; f < 4; f++)
         send_frame($urandom_range(1, 6), $urandom_range(1, 8), $urandom_range(0, 2),
                    1'($urandom_range(0, 3) == 0));

      // heartbeat after transmit in slow half duplex
      @(negedge clk);
      full = 1'b0; rep = 1'b0; ract = 1'b0; tx = 1'b1;
      repeat (4) @(negedge clk);
      tx = 1'b0;
      for (int j = 1; j <= GAP + LEN + 3; j++) begin
         @(negedge clk);
         check("R9 heartbeat", col_o, (j >= GAP + 2) && (j <= GAP + LEN + 1));
      end

      // gate enable has no effect in slow mode
      gen = 1'b1;
      for (int i = 0; i < 90; i++) begin
         step();
         check("R10 slow never held", rx_clk_o, (cnt % (2 * HS)) >= HS);
      end

      // fast mode with idle clock hold
      do_reset(1'b1, 1'b1);
      while (cnt < 6 * 2 * HF) begin
         step();
         check("R10 idle hold", rx_clk_o, (cnt >= HF) && (cnt < 2 * HF));
      end
      to_tick();
      t0 = cnt;
      ract = 1'b1; nib = 4'h5; pre = 1'b1;
      while (cnt < t0 + 2 * HF) step();
      ract = 1'b0; nib = 4'h0; pre = 1'b0;
      while (cnt < t0 + 4 * HF) begin
         step();
         check("R10 wake clock", rx_clk_o, (cnt >= t0 + 3 * HF) && (cnt < t0 + 4 * HF));
         if (cnt < t0 + 4 * HF) check("R10 dv waits", rx_dv_o, 0);
      end
      check("R4 dv on first preamble nibble", rx_dv_o, 1);
      check("R4 preamble nibble value", rxd_o, 5);
      while (cnt < t0 + 6 * HF) begin
         step();
         check("R10 last clock", rx_clk_o, (cnt >= t0 + 5 * HF) && (cnt < t0 + 6 * HF));
      end
      check("R6 dv drops", rx_dv_o, 0);
      for (int i = 0; i < 20; i++) begin
         step();
         check("R10 held again", rx_clk_o, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule